// File: doc/BRIEF.md
# Combinable Skip Condition Evaluator

This block decides whether the skip-class instruction of an 18-bit one's-complement processor should skip over the following instruction. In a single cycle it reads the instruction's 12-bit selector field, its sense-reversal bit, and a snapshot of machine state. That state is the accumulator, the in-out register, the overflow flag, six operator switches and six program flags. A decision to skip tells the sequencer to advance the program counter one extra place.

Several tests can be selected at once, and the decision is the inclusive OR of all selected tests. The reversal bit then inverts that final result. The switch group and the flag group each use a 3-bit selector: the value 0 selects nothing, the values 1 to 6 test one member for zero, and the value 7 requires every member to be zero.

Whenever the overflow test is selected, the block also pulses a strobe that tells the owner of the overflow flag to clear it. Both outputs are registered and are issued only for a cycle in which the execute enable is high.

Top module: `skp_eval`

## Requirements
- R1: Selector bit 6 (octal 0100) is true when every accumulator bit is 0. An all-ones accumulator (minus zero) does not satisfy it.
- R2: Selector bit 7 (octal 0200) is true when accumulator bit 17 (the sign) is 0. Selector bit 8 (octal 0400) is true when that sign is 1.
- R3: Selector bit 10 (octal 2000) is true when bit 17 of the in-out register (its sign) is 0.
- R4: Selector bit 9 (octal 1000) is true when the overflow input is 0. Whenever this bit is selected, `ovf_clr_q` pulses, whatever the final decision.
- R5: Selector bits 5:3 pick a switch. Value k in 1..6 is true when `sense_sw[k-1]` is 0. Value 7 is true only when all six switches are 0. Value 0 contributes false.
- R6: Selector bits 2:0 pick a program flag, with the same rules on `prog_flag`.
- R7: With several tests selected, the decision is true if any selected test is true.
- R8: `inv` = 1 reverses the final decision.
- R9: With no test selected, the block never skips when `inv` = 0 and always skips when `inv` = 1.
- R10: The outputs appear one clock after a cycle with `exec_en` high and last one cycle. After a cycle with `exec_en` low, both outputs are 0.
- R11: During reset, both outputs are 0.
- R12: Selector bit 11 (octal 4000) selects no test and has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_en | input | 1 | A skip instruction is executing this cycle |
| inv | input | 1 | Reverses the final decision |
| addr | input | 12 | Condition selector field |
| ac | input | 18 | Accumulator value |
| io | input | 18 | In-out register value |
| ovf | input | 1 | Overflow flag |
| sense_sw | input | 6 | Operator switches; bit k-1 is switch k |
| prog_flag | input | 6 | Program flags; bit k-1 is flag k |
| skip_q | output | 1 | Registered skip decision strobe |
| ovf_clr_q | output | 1 | Registered overflow-clear strobe |

## Verification
The assertions assume that all inputs hold known values at each rising edge once reset is released. They also assume that the machine state in the cycle where `exec_en` is sampled is the state the decision is about. The bench respects both assumptions: it changes every input only on falling edges and keeps reset low across the first edges. It also sets the unused selector values (bit 11, and the unselected state words) to deliberately misleading values, so any leakage of an unselected test into the OR shows up at `skip_q`.

// File: rtl/skp_pkg.sv
package skp_pkg;
  // Bit positions inside the 12-bit selector field (behaviour depends on them)
  localparam int unsigned POS_ACZ = 6;   // accumulator plus zero
  localparam int unsigned POS_ACP = 7;   // accumulator sign clear
  localparam int unsigned POS_ACM = 8;   // accumulator sign set
  localparam int unsigned POS_OVZ = 9;   // overflow clear, also requests clear
  localparam int unsigned POS_IOP = 10;  // in-out sign clear
  localparam int unsigned GRP_W   = 3;   // width of each group selector
  localparam int unsigned GRP_N   = 2;   // flag group and switch group

  // Per-test hit vector, brought out for assertions
  typedef struct packed {
    logic acz;
    logic acp;
    logic acm;
    logic ovz;
    logic iop;
    logic sw;
    logic fl;
  } hits_t;
endpackage

// File: rtl/skp_word_tests.sv
module skp_word_tests #(
  parameter int unsigned WORD_W = 18
) (
  input  logic              sel_acz,
  input  logic              sel_acp,
  input  logic              sel_acm,
  input  logic              sel_ovz,
  input  logic              sel_iop,
  input  logic [WORD_W-1:0] ac,
  input  logic [WORD_W-1:0] io,
  input  logic              ovf,
  output logic              hit_acz,
  output logic              hit_acp,
  output logic              hit_acm,
  output logic              hit_ovz,
  output logic              hit_iop
);
  localparam int unsigned SIGN = WORD_W - 1;

  // Plus zero only: minus zero (all ones) is a different bit pattern
  function automatic logic is_plus_zero(input logic [WORD_W-1:0] w);
    return (w == '0);
  endfunction

  function automatic logic is_non_negative(input logic [WORD_W-1:0] w);
    return ~w[SIGN];
  endfunction

  always_comb begin
    hit_acz = sel_acz & is_plus_zero(ac);
    hit_acp = sel_acp & is_non_negative(ac);
    hit_acm = sel_acm & ~is_non_negative(ac);
    hit_ovz = sel_ovz & ~ovf;
    hit_iop = sel_iop & is_non_negative(io);
  end
endmodule

// File: rtl/skp_group_test.sv
module skp_group_test #(
  parameter int unsigned MEMB_N = 6,
  parameter int unsigned SEL_W  = 3
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [MEMB_N-1:0] memb,
  output logic              hit
);
  localparam logic [SEL_W-1:0] SEL_ALL = {SEL_W{1'b1}};

  // 0: nothing; 1..MEMB_N: that member is zero; all-ones: every member zero
  function automatic logic group_zero(input logic [SEL_W-1:0] s,
                                      input logic [MEMB_N-1:0] m);
    logic r;
    r = 1'b0;
    if (s == SEL_ALL) begin
      r = (m == '0);
    end else begin
      for (int k = 1; k <= int'(MEMB_N); k++) begin
        if (int'(s) == k) r = ~m[k-1];
      end
    end
    return r;
  endfunction

  assign hit = group_zero(sel, memb);
endmodule

// File: rtl/skp_eval.sv
module skp_eval #(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned MEMB_N = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic              inv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] ac,
  input  logic [WORD_W-1:0] io,
  input  logic              ovf,
  input  logic [MEMB_N-1:0] sense_sw,
  input  logic [MEMB_N-1:0] prog_flag,
  output logic              skip_q,
  output logic              ovf_clr_q
);
  import skp_pkg::*;

  localparam int unsigned FLD_W = GRP_W;

  skp_pkg::hits_t hits;
  logic cond_hit;
  logic skip_next;
  logic clr_next;

  logic [FLD_W-1:0]  grp_sel  [GRP_N];
  logic [MEMB_N-1:0] grp_memb [GRP_N];
  logic [GRP_N-1:0]  grp_hit;

  // group 0: program flags at bits 2:0, group 1: switches at bits 5:3
  assign grp_sel[0]  = addr[FLD_W-1:0];
  assign grp_sel[1]  = addr[2*FLD_W-1:FLD_W];
  assign grp_memb[0] = prog_flag;
  assign grp_memb[1] = sense_sw;

  skp_word_tests #(.WORD_W(WORD_W)) u_words (
    .sel_acz (addr[POS_ACZ]),
    .sel_acp (addr[POS_ACP]),
    .sel_acm (addr[POS_ACM]),
    .sel_ovz (addr[POS_OVZ]),
    .sel_iop (addr[POS_IOP]),
    .ac      (ac),
    .io      (io),
    .ovf     (ovf),
    .hit_acz (hits.acz),
    .hit_acp (hits.acp),
    .hit_acm (hits.acm),
    .hit_ovz (hits.ovz),
    .hit_iop (hits.iop)
  );

  for (genvar g = 0; g < int'(GRP_N); g++) begin : g_grp
    skp_group_test #(.MEMB_N(MEMB_N), .SEL_W(FLD_W)) u_grp (
      .sel  (grp_sel[g]),
      .memb (grp_memb[g]),
      .hit  (grp_hit[g])
    );
  end

  assign hits.fl = grp_hit[0];
  assign hits.sw = grp_hit[1];

  assign cond_hit  = |hits;
  assign skip_next = exec_en & (cond_hit ^ inv);
  assign clr_next  = exec_en & addr[POS_OVZ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_q    <= 1'b0;
      ovf_clr_q <= 1'b0;
    end else begin
      skip_q    <= skip_next;
      ovf_clr_q <= clr_next;
    end
  end
endmodule

// File: rtl/skp_eval_chk.sv
module skp_eval_chk #(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned MEMB_N = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exec_en,
  input logic              inv,
  input logic [ADDR_W-1:0] addr,
  input logic [WORD_W-1:0] ac,
  input logic [WORD_W-1:0] io,
  input logic              ovf,
  input logic [MEMB_N-1:0] sense_sw,
  input logic [MEMB_N-1:0] prog_flag,
  input logic              skip_q,
  input logic              ovf_clr_q,
  input logic              cond_hit
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> (!skip_q && !ovf_clr_q)); // R10
  AST_CLR_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && addr[9]) |=> ovf_clr_q); // R4
  AST_CLR_ONLY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !addr[9] |=> !ovf_clr_q); // R4
  AST_PLUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !inv && addr[6] && ac == '0) |=> skip_q); // R1
  AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !inv && addr[9] && !ovf) |=> skip_q); // R7
  AST_NONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && addr[10:0] == '0) |=> (skip_q == $past(inv))); // R9
  AST_REVERSAL: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |=> (skip_q == ($past(cond_hit) ^ $past(inv)))); // R8
  AST_ALL_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !inv && addr[5:3] == 3'd7 && sense_sw == '0) |=> skip_q); // R5
  AST_IO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !inv && addr[10] && !io[WORD_W-1]) |=> skip_q); // R3
  AST_FLAG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !inv && addr[2:0] == 3'd1 && !prog_flag[0]) |=> skip_q); // R6
endmodule

bind skp_eval skp_eval_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .MEMB_N(MEMB_N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exec_en   (exec_en),
  .inv       (inv),
  .addr      (addr),
  .ac        (ac),
  .io        (io),
  .ovf       (ovf),
  .sense_sw  (sense_sw),
  .prog_flag (prog_flag),
  .skip_q    (skip_q),
  .ovf_clr_q (ovf_clr_q),
  .cond_hit  (cond_hit)
);

// File: tb/skp_eval_bench.sv
module skp_eval_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic        inv = 1'b0;
  logic [11:0] addr = '0;
  logic [17:0] ac = '0;
  logic [17:0] io = '0;
  logic        ovf = 1'b0;
  logic [5:0]  sense_sw = '0;
  logic [5:0]  prog_flag = '0;
  logic        skip_q;
  logic        ovf_clr_q;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  skp_eval u_skp_eval (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .inv(inv), .addr(addr),
    .ac(ac), .io(io), .ovf(ovf), .sense_sw(sense_sw), .prog_flag(prog_flag),
    .skip_q(skip_q), .ovf_clr_q(ovf_clr_q)
  );

  typedef struct packed {
    logic [11:0] addr;
    logic        inv;
    logic [17:0] ac;
    logic [17:0] io;
    logic        ovf;
    logic [5:0]  sw;
    logic [5:0]  fl;
    logic        skip;
    logic        clr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{12'o0100, 1'b0, 18'o000000, 18'o400000, 1'b1, 6'o77, 6'o77, 1'b1, 1'b0, 8'd1},  // R1 plus zero
    '{12'o0100, 1'b0, 18'o777777, 18'o000000, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 8'd1},  // R1 minus zero
    '{12'o0200, 1'b0, 18'o377777, 18'o400000, 1'b1, 6'o77, 6'o77, 1'b1, 1'b0, 8'd2},  // R2 plus
    '{12'o0200, 1'b0, 18'o400000, 18'o000000, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 8'd2},  // R2 plus fails
    '{12'o0400, 1'b0, 18'o400000, 18'o400000, 1'b1, 6'o77, 6'o77, 1'b1, 1'b0, 8'd2},  // R2 minus
    '{12'o0400, 1'b0, 18'o000000, 18'o000000, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 8'd2},  // R2 minus fails
    '{12'o2000, 1'b0, 18'o000000, 18'o400000, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 8'd3},  // R3 io negative
    '{12'o2000, 1'b0, 18'o777777, 18'o000001, 1'b1, 6'o77, 6'o77, 1'b1, 1'b0, 8'd3},  // R3 io positive
    '{12'o1000, 1'b0, 18'o000000, 18'o000000, 1'b1, 6'o00, 6'o00, 1'b0, 1'b1, 8'd4},  // R4 ovf set
    '{12'o1000, 1'b0, 18'o777777, 18'o400000, 1'b0, 6'o77, 6'o77, 1'b1, 1'b1, 8'd4},  // R4 ovf clear
    '{12'o1000, 1'b1, 18'o000000, 18'o000000, 1'b0, 6'o00, 6'o00, 1'b0, 1'b1, 8'd4},  // R4 clear despite reversal
    '{12'o0030, 1'b0, 18'o777777, 18'o400000, 1'b1, 6'o73, 6'o00, 1'b1, 1'b0, 8'd5},  // R5 switch 3 zero
    '{12'o0030, 1'b0, 18'o000000, 18'o000000, 1'b0, 6'o04, 6'o00, 1'b0, 1'b0, 8'd5},  // R5 switch 3 set
    '{12'o0070, 1'b0, 18'o777777, 18'o400000, 1'b1, 6'o00, 6'o77, 1'b1, 1'b0, 8'd5},  // R5 all zero
    '{12'o0070, 1'b0, 18'o000000, 18'o000000, 1'b0, 6'o40, 6'o00, 1'b0, 1'b0, 8'd5},  // R5 switch 6 set
    '{12'o0005, 1'b0, 18'o777777, 18'o400000, 1'b1, 6'o00, 6'o57, 1'b1, 1'b0, 8'd6},  // R6 flag 5 zero
    '{12'o0007, 1'b0, 18'o000000, 18'o000000, 1'b0, 6'o00, 6'o01, 1'b0, 1'b0, 8'd6},  // R6 flag 1 set
    '{12'o3000, 1'b0, 18'o000000, 18'o400000, 1'b1, 6'o00, 6'o00, 1'b0, 1'b1, 8'd7},  // R7 neither true
    '{12'o3000, 1'b0, 18'o000000, 18'o000000, 1'b1, 6'o00, 6'o00, 1'b1, 1'b1, 8'd7},  // R7 io term true
    '{12'o0100, 1'b1, 18'o000000, 18'o000000, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 8'd8},  // R8 reversed
    '{12'o0000, 1'b0, 18'o000000, 18'o000000, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 8'd9},  // R9 no select
    '{12'o0000, 1'b1, 18'o777777, 18'o400000, 1'b1, 6'o77, 6'o77, 1'b1, 1'b0, 8'd9},  // R9 always skip
    '{12'o4000, 1'b0, 18'o000000, 18'o000000, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 8'd12}  // R12 bit 11 inert
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic en);
    addr = v.addr; inv = v.inv; ac = v.ac; io = v.io;
    ovf = v.ovf; sense_sw = v.sw; prog_flag = v.fl; exec_en = en;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    vec_t d;
    // R11: outputs idle while reset holds, even with a live request
    d = TBL[0];
    drive(d, 1'b1);
    repeat (3) @(negedge clk);
    check("R11", skip_q, 1'b0, "skip in reset");
    check("R11", ovf_clr_q, 1'b0, "clear in reset");
    exec_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i], 1'b1);
      @(negedge clk);
      check($sformatf("R%0d", TBL[i].req), skip_q, TBL[i].skip, $sformatf("row %0d skip", i));
      check($sformatf("R%0d", TBL[i].req), ovf_clr_q, TBL[i].clr, $sformatf("row %0d clear", i));
    end

    // R10: enable low with conditions true yields no strobes
    d = TBL[9];
    @(negedge clk);
    drive(d, 1'b0);
    @(negedge clk);
    check("R10", skip_q, 1'b0, "skip with enable low");
    check("R10", ovf_clr_q, 1'b0, "clear with enable low");

    // R10: strobe lasts exactly one cycle after a single enabled cycle
    @(negedge clk);
    drive(d, 1'b1);
    @(negedge clk);
    exec_en = 1'b0;
    check("R10", skip_q, 1'b1, "strobe present");
    check("R10", ovf_clr_q, 1'b1, "clear present");
    @(negedge clk);
    check("R10", skip_q, 1'b0, "strobe ended");
    check("R10", ovf_clr_q, 1'b0, "clear ended");

    // R12: bit 11 alongside a failing accumulator test changes nothing
    d = TBL[1];
    d.addr = 12'o4100;
    @(negedge clk);
    drive(d, 1'b1);
    @(negedge clk);
    check("R12", skip_q, 1'b0, "bit 11 with minus zero");

    // R6: flag 6 tested alone with flag 6 clear, others set
    d = TBL[16];
    d.addr = 12'o0006; d.fl = 6'o37;
    @(negedge clk);
    drive(d, 1'b1);
    @(negedge clk);
    check("R6", skip_q, 1'b1, "flag 6 zero");

    exec_en = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule